// File: doc/BRIEF.md
# DSP Multiply-Accumulate Product Unit

This block is the multiply datapath of a small 16-bit audio signal processor. It keeps a 40-bit product register. On each strobed cycle it runs one operation chosen by a 3-bit opcode: plain multiply, multiply-add, multiply-subtract, clear, two move variants, a cross-multiply, and a fold of the product into an accumulator. Move variants save the old product to the accumulator path in the same step that the new product overwrites it.

Two mode inputs shape the multiply. The first, `no_dbl_i`, suppresses the default doubling of the product. The second, `unsigned_i`, makes the operands unsigned, but only for the cross-multiply. The cross-multiply takes its operands from halves of two 32-bit secondary registers. The unit also reports zero and negative flags for the value each operation writes.

Top module: `mac_prod_unit`

## Requirements
- R1: While `rst_ni` is low and after reset, `prod_o`, `acc_o`, `valid_o`, `acc_we_o`, `zero_o` and `neg_o` are all 0.
- R2: Opcode 0 (multiply) stores the signed 16x16 product of `opa_i` and `opb_i`, sign-extended to 40 bits. The product is shifted left by one when `no_dbl_i` is 0 and left unshifted when it is 1. The doubling rule applies to every multiplying opcode.
- R3: Opcode 1 stores the old product plus the new term. Opcode 2 stores the old product minus the new term. Both wrap modulo 2^40.
- R4: Opcode 3 sets the product to zero and does not write the accumulator.
- R5: Opcode 6 (cross-multiply) multiplies a half of `sec0_i` by a half of `sec1_i`. `xsel_i[1]` picks the half of `sec0_i` and `xsel_i[0]` picks the half of `sec1_i`. A selector value of 0 picks bits [15:0] and 1 picks bits [31:16].
- R6: With `unsigned_i` = 1, opcode 6 treats both operands as unsigned. Every other multiplying opcode stays signed whatever the value of `unsigned_i`.
- R7: Opcode 4 drives `acc_o` with the old product. Opcode 5 drives `acc_o` with `acc_i` plus the old product. Both store the new multiply term in the product and raise `acc_we_o`.
- R8: Opcode 7 drives `acc_o` with ((product with bits [15:0] cleared) + `acc_i`), with bits [15:0] of the result cleared. It raises `acc_we_o` and leaves the product unchanged.
- R9: `zero_o` shows that the written value is 0, and `neg_o` shows bit 39 of the written value. The written value is `acc_o` for opcodes 4, 5 and 7, and the product for the other opcodes.
- R10: Results, flags and `valid_o` appear one cycle after `valid_i`. With `valid_i` low, the product and flags hold and `valid_o` and `acc_we_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Operation strobe |
| op_i | input | 3 | Opcode |
| opa_i | input | 16 | First operand for non-cross opcodes |
| opb_i | input | 16 | Second operand for non-cross opcodes |
| sec0_i | input | 32 | Secondary register 0 (high:low) |
| sec1_i | input | 32 | Secondary register 1 (high:low) |
| xsel_i | input | 2 | Cross half selectors |
| acc_i | input | 40 | Accumulator addend |
| no_dbl_i | input | 1 | 1 suppresses product doubling |
| unsigned_i | input | 1 | 1 makes cross-multiply unsigned |
| prod_o | output | 40 | Product register |
| acc_o | output | 40 | Accumulator result |
| acc_we_o | output | 1 | Accumulator result valid |
| valid_o | output | 1 | Operation completed |
| zero_o | output | 1 | Written value is zero |
| neg_o | output | 1 | Written value is negative |

## Verification
A corrupt product register appears on `prod_o` one cycle after the operation that caused it. It also shows up in the next accumulate, subtract or move, so a bad state spreads into `acc_o` at the very next strobe. A wrong operand-half choice or a wrong signedness shows only for some operand values. Examples are 0x8000 squared, 0xFFFF under unsigned mode, and operands whose halves differ. The bench compares every cycle against a behavioural model, drives these values directly, and then runs a long random mix of opcodes and modes.

// File: rtl/mac_pkg.sv
package mac_pkg;
  typedef enum logic [2:0] {
    OP_MUL      = 3'd0,
    OP_MADD     = 3'd1,
    OP_MSUB     = 3'd2,
    OP_CLR      = 3'd3,
    OP_MOVE     = 3'd4,
    OP_MOVE_ACC = 3'd5,
    OP_XMUL     = 3'd6,
    OP_ADDPA    = 3'd7
  } mac_op_e;
endpackage

// File: rtl/mac_xsel.sv
module mac_xsel #(
  parameter int DW = 16
) (
  input  logic [2*DW-1:0] sec0_i,
  input  logic [2*DW-1:0] sec1_i,
  input  logic [1:0]      xsel_i,
  output logic [DW-1:0]   xa_o,
  output logic [DW-1:0]   xb_o
);
  logic [2*DW-1:0] src  [2];
  logic [DW-1:0]   pick [2];

  assign src[0] = sec0_i;
  assign src[1] = sec1_i;

  // xsel_i[1] steers register 0, xsel_i[0] steers register 1
  for (genvar g = 0; g < 2; g++) begin : g_half
    assign pick[g] = xsel_i[1-g] ? src[g][2*DW-1:DW] : src[g][DW-1:0];
  end

  assign xa_o = pick[0];
  assign xb_o = pick[1];
endmodule

// File: rtl/mac_term.sv
module mac_term #(
  parameter int DW = 16,
  parameter int PW = 40
) (
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  logic          uns_i,
  input  logic          no_dbl_i,
  output logic [PW-1:0] term_o
);
  localparam int RW = 2*DW + 2;

  logic signed [DW:0]   ea, eb;
  logic signed [RW-1:0] raw;
  logic [PW-1:0]        ext;

  assign ea  = {uns_i ? 1'b0 : a_i[DW-1], a_i};
  assign eb  = {uns_i ? 1'b0 : b_i[DW-1], b_i};
  assign raw = ea * eb;
  assign ext = {{(PW-RW){raw[RW-1]}}, raw};
  assign term_o = no_dbl_i ? ext : (ext << 1);
endmodule

// File: rtl/mac_acc_path.sv
module mac_acc_path
  import mac_pkg::*;
#(
  parameter int PW = 40,
  parameter int MW = 16
) (
  input  mac_op_e       op_i,
  input  logic [PW-1:0] prod_i,
  input  logic [PW-1:0] acc_i,
  output logic [PW-1:0] acc_o
);
  localparam logic [PW-1:0] HI_MASK = {{(PW-MW){1'b1}}, {MW{1'b0}}};

  always_comb begin
    unique case (op_i)
      OP_MOVE:     acc_o = prod_i;
      OP_MOVE_ACC: acc_o = prod_i + acc_i;
      OP_ADDPA:    acc_o = ((prod_i & HI_MASK) + acc_i) & HI_MASK;
      default:     acc_o = acc_i;
    endcase
  end
endmodule

// File: rtl/mac_prod_unit.sv
module mac_prod_unit
  import mac_pkg::*;
#(
  parameter int DW = 16,
  parameter int PW = 40,
  parameter int MW = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            valid_i,
  input  logic [2:0]      op_i,
  input  logic [DW-1:0]   opa_i,
  input  logic [DW-1:0]   opb_i,
  input  logic [2*DW-1:0] sec0_i,
  input  logic [2*DW-1:0] sec1_i,
  input  logic [1:0]      xsel_i,
  input  logic [PW-1:0]   acc_i,
  input  logic            no_dbl_i,
  input  logic            unsigned_i,
  output logic [PW-1:0]   prod_o,
  output logic [PW-1:0]   acc_o,
  output logic            acc_we_o,
  output logic            valid_o,
  output logic            zero_o,
  output logic            neg_o
);
  mac_op_e       op;
  logic [DW-1:0] xa, xb, ma, mb;
  logic          is_x, acc_wr;
  logic [PW-1:0] term, prod_d, acc_d, flag_src;
  logic [PW-1:0] prod_q, acc_q;
  logic          valid_q, acc_we_q, zero_q, neg_q;

  assign op   = mac_op_e'(op_i);
  assign is_x = (op == OP_XMUL);

  mac_xsel #(.DW(DW)) u_xsel (
    .sec0_i (sec0_i),
    .sec1_i (sec1_i),
    .xsel_i (xsel_i),
    .xa_o   (xa),
    .xb_o   (xb)
  );

  assign ma = is_x ? xa : opa_i;
  assign mb = is_x ? xb : opb_i;

  mac_term #(.DW(DW), .PW(PW)) u_term (
    .a_i      (ma),
    .b_i      (mb),
    .uns_i    (is_x & unsigned_i),
    .no_dbl_i (no_dbl_i),
    .term_o   (term)
  );

  mac_acc_path #(.PW(PW), .MW(MW)) u_acc (
    .op_i   (op),
    .prod_i (prod_q),
    .acc_i  (acc_i),
    .acc_o  (acc_d)
  );

  always_comb begin
    unique case (op)
      OP_MADD:  prod_d = prod_q + term;
      OP_MSUB:  prod_d = prod_q - term;
      OP_CLR:   prod_d = '0;
      OP_ADDPA: prod_d = prod_q;
      default:  prod_d = term;
    endcase
  end

  assign acc_wr   = (op == OP_MOVE) || (op == OP_MOVE_ACC) || (op == OP_ADDPA);
  assign flag_src = acc_wr ? acc_d : prod_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prod_q   <= '0;
      acc_q    <= '0;
      valid_q  <= 1'b0;
      acc_we_q <= 1'b0;
      zero_q   <= 1'b0;
      neg_q    <= 1'b0;
    end else begin
      valid_q  <= valid_i;
      acc_we_q <= valid_i & acc_wr;
      if (valid_i) begin
        prod_q <= prod_d;
        zero_q <= (flag_src == '0);
        neg_q  <= flag_src[PW-1];
        if (acc_wr) acc_q <= acc_d;
      end
    end
  end

  assign prod_o   = prod_q;
  assign acc_o    = acc_q;
  assign acc_we_o = acc_we_q;
  assign valid_o  = valid_q;
  assign zero_o   = zero_q;
  assign neg_o    = neg_q;
endmodule

// File: rtl/mac_prod_unit_chk.sv
module mac_prod_unit_chk #(
  parameter int DW = 16,
  parameter int PW = 40,
  parameter int MW = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          valid_i,
  input logic [2:0]    op_i,
  input logic [DW-1:0] opa_i,
  input logic [PW-1:0] prod_o,
  input logic [PW-1:0] acc_o,
  input logic          acc_we_o,
  input logic          valid_o,
  input logic          zero_o,
  input logic          neg_o
);
  // R10
  vld_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);

  // R10
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> (!valid_o && !acc_we_o && $stable(prod_o)));

  // R4
  clr_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == 3'd3) |=> (prod_o == '0 && zero_o && !acc_we_o));

  // R3
  zero_term_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && (op_i == 3'd1 || op_i == 3'd2) && opa_i == '0) |=> $stable(prod_o));

  // R7
  move_old_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == 3'd4) |=> (acc_we_o && acc_o == $past(prod_o)));

  // R8
  addpa_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == 3'd7) |=> (acc_we_o && acc_o[MW-1:0] == '0 && $stable(prod_o)));

  // R9
  prod_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !acc_we_o) |-> (zero_o == (prod_o == '0) && neg_o == prod_o[PW-1]));

  // R9
  acc_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_we_o |-> (zero_o == (acc_o == '0) && neg_o == acc_o[PW-1]));
endmodule

bind mac_prod_unit mac_prod_unit_chk #(.DW(DW), .PW(PW), .MW(MW)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .valid_i  (valid_i),
  .op_i     (op_i),
  .opa_i    (opa_i),
  .prod_o   (prod_o),
  .acc_o    (acc_o),
  .acc_we_o (acc_we_o),
  .valid_o  (valid_o),
  .zero_o   (zero_o),
  .neg_o    (neg_o)
);

// File: tb/tb_mac_prod_unit.sv
module tb_mac_prod_unit;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [2:0]  op_i = '0;
  logic [15:0] opa_i = '0, opb_i = '0;
  logic [31:0] sec0_i = '0, sec1_i = '0;
  logic [1:0]  xsel_i = '0;
  logic [39:0] acc_i = '0;
  logic        no_dbl_i = 1'b0, unsigned_i = 1'b0;
  logic [39:0] prod_o, acc_o;
  logic        acc_we_o, valid_o, zero_o, neg_o;

  int n_chk = 0;
  int n_err = 0;
  logic [39:0] m_prod = '0;
  logic [39:0] m_acc  = '0;
  bit          m_zero = 0, m_neg = 0;

  always #2 clk_i = ~clk_i;

  mac_prod_unit dut (.*);

  task automatic chk(string tag, logic [39:0] act, logic [39:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [39:0] m_term(logic [15:0] a, logic [15:0] b, bit uns, bit nd);
    longint p;
    if (uns) p = longint'(a) * longint'(b);
    else     p = longint'($signed(a)) * longint'($signed(b));
    if (!nd) p = p * 2;
    return p[39:0];
  endfunction

  function automatic string tag_of(int op);
    case (op)
      0: return "R2";
      1, 2: return "R3";
      3: return "R4";
      4, 5: return "R7";
      6: return "R5";
      default: return "R8";
    endcase
  endfunction

  task automatic run_op(int op, logic [15:0] a, logic [15:0] b, logic [31:0] s0,
                        logic [31:0] s1, logic [1:0] xs, logic [39:0] acc, bit nd, bit uns);
    logic [15:0] xa, xb;
    logic [39:0] t, wv;
    bit          awr;
    valid_i = 1; op_i = 3'(op); opa_i = a; opb_i = b; sec0_i = s0; sec1_i = s1;
    xsel_i = xs; acc_i = acc; no_dbl_i = nd; unsigned_i = uns;
    xa = xs[1] ? s0[31:16] : s0[15:0];
    xb = xs[0] ? s1[31:16] : s1[15:0];
    t = (op == 6) ? m_term(xa, xb, uns, nd) : m_term(a, b, 1'b0, nd);
    awr = (op == 4 || op == 5 || op == 7);
    case (op)
      4: m_acc = m_prod;
      5: m_acc = 40'(m_prod + acc);
      7: m_acc = 40'((((m_prod >> 16) << 16) + acc) >> 16) << 16;
      default: ;
    endcase
    case (op)
      1: m_prod = 40'(m_prod + t);
      2: m_prod = 40'(m_prod - t);
      3: m_prod = '0;
      7: ;
      default: m_prod = t;
    endcase
    wv = awr ? m_acc : m_prod;
    m_zero = (wv == 0);
    m_neg = wv[39];
    @(posedge clk_i);
    @(negedge clk_i);
    valid_i = 0;
    chk(tag_of(op), prod_o, m_prod);
    chk("R10", 40'(valid_o), 40'd1);
    chk(tag_of(op), 40'(acc_we_o), 40'(awr));
    if (awr) chk(tag_of(op), acc_o, m_acc);
    chk("R9", 40'(zero_o), 40'(m_zero));
    chk("R9", 40'(neg_o), 40'(m_neg));
  endtask

  task automatic idle();
    valid_i = 0; op_i = 3'd3; opa_i = 16'h1234;
    @(posedge clk_i);
    @(negedge clk_i);
    chk("R10", prod_o, m_prod);
    chk("R10", 40'(valid_o), 40'd0);
    chk("R10", 40'(acc_we_o), 40'd0);
    chk("R10", 40'(zero_o), 40'(m_zero));
  endtask

  initial begin
    #(4 * 150000);
    n_err++;
    $display("FAIL watchdog act=hung exp=done");
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk("R1", prod_o, 40'd0);
    chk("R1", 40'({valid_o, acc_we_o, zero_o, neg_o}), 40'd0);
    chk("R1", acc_o, 40'd0);
    rst_ni = 1;
    @(negedge clk_i);
    chk("R1", prod_o, 40'd0);

    // R2 signed corners, doubled and not
    run_op(0, 16'h8000, 16'h8000, 0, 0, 0, 0, 0, 0);
    run_op(0, 16'h8000, 16'h8000, 0, 0, 0, 0, 1, 0);
    run_op(0, 16'hFFFF, 16'h0003, 0, 0, 0, 0, 0, 0);
    // R6 unsigned ignored outside cross-multiply
    run_op(0, 16'hFFFF, 16'hFFFF, 0, 0, 0, 0, 0, 1);
    // R3 add, subtract, wrap
    run_op(1, 16'h7FFF, 16'h7FFF, 0, 0, 0, 0, 1, 0);
    run_op(2, 16'h0001, 16'h0005, 0, 0, 0, 0, 0, 0);
    run_op(3, 0, 0, 0, 0, 0, 0, 0, 0);
    run_op(2, 16'h0001, 16'h0001, 0, 0, 0, 0, 1, 0);
    // R4
    run_op(3, 16'h1111, 16'h2222, 0, 0, 0, 0, 0, 0);
    // R5 each selector combination
    for (int s = 0; s < 4; s++)
      run_op(6, 0, 0, 32'h0003_FFFE, 32'h0005_0007, 2'(s), 0, 1, 0);
    // R6 unsigned cross-multiply
    run_op(6, 0, 0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 2'b11, 0, 0, 1);
    run_op(6, 0, 0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 2'b00, 0, 0, 0);
    // R7 move variants
    run_op(4, 16'h0010, 16'h0010, 0, 0, 0, 0, 1, 0);
    run_op(5, 16'h8000, 16'h0001, 0, 0, 0, 40'hFF_FFFF_FF00, 0, 0);
    // R8 add product with masking
    run_op(0, 16'h1234, 16'h5678, 0, 0, 0, 0, 0, 0);
    run_op(7, 0, 0, 0, 0, 0, 40'h00_0001_FFFF, 0, 0);
    // R10 hold while idle
    idle();
    idle();

    for (int i = 0; i < 3000; i++) begin
      run_op(int'($urandom_range(0, 7)), 16'($urandom), 16'($urandom), $urandom, $urandom,
             2'($urandom), {8'($urandom), 32'($urandom)}, 1'($urandom), 1'($urandom));
      if ($urandom_range(0, 9) == 0) idle();
    end

    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule